// File: doc/BRIEF.md
# Dual-Rate Pin Event Detector

This block watches two external input pins and turns activity on them into sticky interrupt flags. The fast pin is treated as a pulse train. Its rising edges are counted, and the fast flag is raised when a programmed number of them arrive within a fixed window of 8192 timebase ticks. The slow pin is treated as a level. A new level is reported only after it has stayed unchanged for a selectable debounce time. Both pins are synchronised to the system clock. All timing advances on a single-cycle tick strobe derived from a 32.768 kHz timebase.

Software uses one 8-bit control/status register. It selects which paths run, the fast-path event count, the slow-path debounce length and a watchdog override. It also reads the two flags and clears them by writing 0. The interrupt output is high while either flag is set. When the override is set, fast-pin detection is suspended and every edge of the fast pin, rising or falling, produces a one-cycle watchdog-clear pulse for an external watchdog timer.

Top module: `evt_pin_detector`

## Requirements
- R1: Register layout, bit 7 down to bit 0: fast flag, slow flag, enable[1:0], watchdog override, debounce select, count select[1:0]. After reset all eight bits read 0. A write stores bits 5:0, and they read back unchanged until the next write.
- R2: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged. Flags are set only by hardware.
- R3: `irq` is high exactly while at least one flag is set.
- R4: Enable bit 5 runs the fast path and enable bit 4 runs the slow path (00 none, 01 slow only, 10 fast only, 11 both). A path that is not enabled never sets its flag.
- R5: Count select 00, 01, 10 and 11 set the fast flag on the 1st, 4th, 16th and 32nd counted rising edge respectively.
- R6: A window of 8192 ticks opens at the first counted edge. If the threshold is not reached by the time the window expires, the count and the window restart, and the next edge opens a new window. Cycles without `tick` do not age the window.
- R7: The slow flag is set once the slow pin has held a new level for 1024 ticks (debounce select 0) or 16384 ticks (select 1). A shorter excursion is ignored.
- R8: While the override bit is 1, each rising or falling edge of the fast pin gives exactly one `wdt_clear` cycle, and the fast path counts nothing.
- R9: While a flag is set, its path does not count. Clearing the flag restarts that path from zero.
- R10: Disabling a path clears its counters at once but leaves an already set flag in place.
- R11: A hardware flag set and a register write carrying 0 in that flag bit in the same cycle leave the flag set.
- R12: The fast path counts rising edges only. A falling edge is not an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the 32.768 kHz timebase |
| fast_pin | input | 1 | Asynchronous fast event input |
| slow_pin | input | 1 | Asynchronous slow event input |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| irq | output | 1 | Interrupt, high while any flag is set |
| wdt_clear | output | 1 | One-cycle watchdog-clear pulse |

## Verification
A hardware flag set and a software register write can land on the same clock edge. The write carries 0 in the flag bit because software last read the flag as clear. The bench provokes this with threshold 1 on the fast path. It raises the fast pin, waits out the two synchroniser stages and the edge register, and issues a write that preserves the control fields with the flag bit at 0 so that the write strobe coincides exactly with the edge on which the flag is set. The flag must read 1 afterwards. If it reads 0, the write was allowed to erase a fresh event.

// File: rtl/evt_pkg.sv
// Package: shared register type and the fast-path threshold decode.
// Assumes the register layout is fixed because software decodes it.
package evt_pkg;

    typedef struct packed {
        logic       fast_flag;   // bit 7
        logic       slow_flag;   // bit 6
        logic [1:0] en;          // bit 5 fast path, bit 4 slow path
        logic       wdt_ovr;     // bit 3
        logic       db_long;     // bit 2
        logic [1:0] cnt_sel;     // bits 1:0
    } evt_csr_t;

    localparam int CNT_W = 6;

    // Maps the count select code to the edge count that raises the fast flag.
    function automatic logic [CNT_W-1:0] fast_threshold(input logic [1:0] sel);
        case (sel)
            2'b00:   fast_threshold = CNT_W'(1);
            2'b01:   fast_threshold = CNT_W'(4);
            2'b10:   fast_threshold = CNT_W'(16);
            default: fast_threshold = CNT_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/evt_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherence is implied.
module evt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage reduces metastability risk.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/evt_fast_path.sv
// Module: fast pin edge counter with a tick-based window, plus the watchdog
// override that turns every fast-pin edge into a one-cycle clear pulse.
// Assumes pin_s is already synchronous. The hit output is combinational and
// is registered in the CSR block.
module evt_fast_path
    import evt_pkg::*;
#(
    parameter int WIN_TICKS = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pin_s,
    input  logic             enable,
    input  logic             override,
    input  logic             flag,
    input  logic [1:0]       cnt_sel,
    output logic             hit,
    output logic             wdt_pulse
);
    localparam int WIN_W = $clog2(WIN_TICKS);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);

    logic             pin_q;
    logic             rise, any_edge, active, expire, base_open;
    logic [CNT_W-1:0] edge_cnt, base_cnt, cnt_inc;
    logic [WIN_W-1:0] win_cnt;
    logic             win_open;

    // Previous pin level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_s;
    end

    // Edge, window-expiry and hit decode.
    always_comb begin
        rise      = pin_s & ~pin_q;
        any_edge  = pin_s ^ pin_q;
        active    = enable & ~override & ~flag;
        expire    = win_open & tick & (win_cnt == WIN_LAST);
        base_cnt  = expire ? '0 : edge_cnt;
        base_open = win_open & ~expire;
        cnt_inc   = base_cnt + CNT_W'(1);
        hit       = active & rise & (cnt_inc >= fast_threshold(cnt_sel));
    end

    // Edge counter and window timer.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || hit) begin
            edge_cnt <= '0;
            win_open <= 1'b0;
            win_cnt  <= '0;
        end else begin
            edge_cnt <= rise ? cnt_inc : base_cnt;
            win_open <= base_open | rise;
            if (base_open && tick) win_cnt <= win_cnt + WIN_W'(1);
            else if (!base_open)   win_cnt <= '0;
        end
    end

    // Watchdog-clear pulse on either edge while the override is set.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_pulse <= 1'b0;
        else        wdt_pulse <= override & any_edge;
    end
endmodule

// File: rtl/evt_slow_path.sv
// Module: slow pin level-change detector with a selectable debounce time.
// Assumes pin_s is synchronous. While the path is idle the reference level
// follows the pin, so enabling the path never reports the level at that moment.
module evt_slow_path #(
    parameter int DB_SHORT = 1024,
    parameter int DB_LONG  = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_s,
    input  logic enable,
    input  logic flag,
    input  logic db_long,
    output logic hit
);
    localparam int DB_W = $clog2(DB_LONG);
    localparam logic [DB_W-1:0] SHORT_LAST = DB_W'(DB_SHORT - 1);
    localparam logic [DB_W-1:0] LONG_LAST  = DB_W'(DB_LONG - 1);

    logic            ref_lvl, active, differs;
    logic [DB_W-1:0] db_cnt, limit;

    // Debounce limit and hit decode.
    always_comb begin
        active  = enable & ~flag;
        differs = pin_s ^ ref_lvl;
        limit   = db_long ? LONG_LAST : SHORT_LAST;
        hit     = active & differs & tick & (db_cnt == limit);
    end

    // Reference level and debounce counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_lvl <= 1'b0;
            db_cnt  <= '0;
        end else if (!active) begin
            ref_lvl <= pin_s;
            db_cnt  <= '0;
        end else if (!differs) begin
            db_cnt  <= '0;
        end else if (tick) begin
            if (hit) begin
                ref_lvl <= pin_s;
                db_cnt  <= '0;
            end else begin
                db_cnt  <= db_cnt + DB_W'(1);
            end
        end
    end
endmodule

// File: rtl/evt_csr.sv
// Module: control/status register. Control fields take a write as given.
// Flags are set by hardware hits and cleared only by writing 0. A hit in the
// same cycle as a clearing write wins.
module evt_csr
    import evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       fast_hit,
    input  logic       slow_hit,
    output evt_csr_t   csr
);
    evt_csr_t wr;
    assign wr = evt_csr_t'(wdata);

    // Register update: control fields by write, flags by set/clear rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr <= '0;
        end else begin
            if (we) begin
                csr.en      <= wr.en;
                csr.wdt_ovr <= wr.wdt_ovr;
                csr.db_long <= wr.db_long;
                csr.cnt_sel <= wr.cnt_sel;
            end
            csr.fast_flag <= fast_hit | (csr.fast_flag & ~(we & ~wr.fast_flag));
            csr.slow_flag <= slow_hit | (csr.slow_flag & ~(we & ~wr.slow_flag));
        end
    end
endmodule

// File: rtl/evt_pin_detector.sv
// Module: top of the dual-rate pin event detector. It ties the synchroniser,
// the two detection paths and the register together.
// Assumes tick is a one-cycle strobe in the clk domain.
module evt_pin_detector
    import evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_TICKS   = 8192,
    parameter int DB_SHORT    = 1024,
    parameter int DB_LONG     = 16384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fast_pin,
    input  logic       slow_pin,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       wdt_clear
);
    logic [1:0] pins_s;
    logic       fast_hit, slow_hit;
    evt_csr_t   csr;

    evt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({slow_pin, fast_pin}), .q(pins_s)
    );

    evt_fast_path #(.WIN_TICKS(WIN_TICKS)) u_fast (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin_s(pins_s[0]),
        .enable(csr.en[1]), .override(csr.wdt_ovr), .flag(csr.fast_flag),
        .cnt_sel(csr.cnt_sel), .hit(fast_hit), .wdt_pulse(wdt_clear)
    );

    evt_slow_path #(.DB_SHORT(DB_SHORT), .DB_LONG(DB_LONG)) u_slow (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin_s(pins_s[1]),
        .enable(csr.en[0]), .flag(csr.slow_flag), .db_long(csr.db_long),
        .hit(slow_hit)
    );

    evt_csr u_csr (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .fast_hit(fast_hit), .slow_hit(slow_hit), .csr(csr)
    );

    // Register view and shared interrupt.
    assign reg_rdata = csr;
    assign irq       = csr.fast_flag | csr.slow_flag;
endmodule

// File: rtl/evt_pin_detector_chk.sv
// Module: port-level checker for evt_pin_detector, bound to every instance.
module evt_pin_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       irq,
    input logic       wdt_clear
);
    // R1: control fields change only through a write.
    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(reg_rdata[5:0]));

    // R2: a set flag survives any cycle without a write.
    p_fast_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && !reg_we) |=> reg_rdata[7]);
    p_slow_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] && !reg_we) |=> reg_rdata[6]);

    // R3: the interrupt only drops after a write.
    p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we));

    // R4 and R8: the fast flag rises only with the fast path on and the override off.
    p_fast_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[7]) |-> ($past(reg_rdata[5]) && !$past(reg_rdata[3])));

    // R4: the slow flag rises only with the slow path on.
    p_slow_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[6]) |-> $past(reg_rdata[4]));

    // R8: watchdog pulses come only from the override.
    p_wdt_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |-> $past(reg_rdata[3]));
endmodule

bind evt_pin_detector evt_pin_detector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .irq(irq), .wdt_clear(wdt_clear)
);

// File: tb/sim_evt_pin_detector.sv
module sim_evt_pin_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       fast_pin = 1'b0;
    logic       slow_pin = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, wdt_clear;

    int n_chk = 0, n_fail = 0, wdt_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    evt_pin_detector u0 (.*);

    // Counts high cycles of the watchdog-clear output.
    always @(negedge clk) if (wdt_clear) wdt_seen++;

    function automatic logic [7:0] ctl(input logic [1:0] en, input logic ovr,
                                       input logic db, input logic [1:0] cs);
        return {2'b00, en, ovr, db, cs};
    endfunction

    function automatic int thr(input logic [1:0] cs);
        case (cs)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 16;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
        wait_n(2);
    endtask

    task automatic fast_pulse(input int gap);
        @(negedge clk); fast_pin = 1'b1; wait_n(gap);
        fast_pin = 1'b0; wait_n(gap);
    endtask

    task automatic pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) fast_pulse(gap);
        wait_n(4);
    endtask

    // Restarts the fast path from zero with the given count select, flags cleared.
    task automatic fast_fresh(input logic [1:0] cs);
        wr(ctl(2'b00, 1'b0, 1'b0, cs));
        wr(ctl(2'b10, 1'b0, 1'b0, cs));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7041));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1 reset value", reg_rdata, 0);
        chk("R3 reset irq", irq, 0);

        // R1 readback of control fields
        wr(8'h3F & ctl(2'b00, 1'b1, 1'b1, 2'b10));
        chk("R1 readback", reg_rdata, 8'h0E);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v = 8'($urandom) & 8'h07;   // paths stay off
            wr(v);
            chk("R1 random readback", reg_rdata[5:0], v[5:0]);
        end
        // R2 writing 1 to flags does not set them
        wr(8'hC0);
        chk("R2 write-one no set", reg_rdata[7:6], 0);

        // R5 thresholds 1 and 4, R3 irq
        fast_fresh(2'b00);
        pulses(1, 3);
        chk("R5 sel00 one edge", reg_rdata[7], 1);
        chk("R3 irq with fast flag", irq, 1);
        // R2 clear with write 0
        wr(ctl(2'b10, 1'b0, 1'b0, 2'b01));
        chk("R2 clear fast flag", reg_rdata[7], 0);
        chk("R3 irq low after clear", irq, 0);
        pulses(3, 3);
        chk("R5 sel01 three edges", reg_rdata[7], 0);
        pulses(1, 3);
        chk("R5 sel01 fourth edge", reg_rdata[7], 1);

        // R9 no counting while flagged, clear restarts from zero
        pulses(3, 3);
        wr(ctl(2'b10, 1'b0, 1'b0, 2'b01));
        pulses(1, 3);
        chk("R9 count restart after clear", reg_rdata[7], 0);

        // R10 disable clears counters, keeps flag
        fast_fresh(2'b01);
        pulses(3, 3);
        wr(ctl(2'b00, 1'b0, 1'b0, 2'b01));
        wr(ctl(2'b10, 1'b0, 1'b0, 2'b01));
        pulses(1, 3);
        chk("R10 disable resets counter", reg_rdata[7], 0);
        pulses(3, 3);
        chk("R10 count after re-enable", reg_rdata[7], 1);
        wr(8'h80 | ctl(2'b00, 1'b0, 1'b0, 2'b01));
        chk("R10 flag kept when disabled", reg_rdata[7], 1);

        // R12 falling edge not counted
        @(negedge clk); fast_pin = 1'b1; wait_n(4);
        fast_fresh(2'b00);
        @(negedge clk); fast_pin = 1'b0; wait_n(6);
        chk("R12 falling edge ignored", reg_rdata[7], 0);
        @(negedge clk); fast_pin = 1'b1; wait_n(6);
        chk("R12 rising edge counted", reg_rdata[7], 1);
        @(negedge clk); fast_pin = 1'b0; wait_n(4);

        // R6 window expiry and restart
        fast_fresh(2'b01);
        pulses(3, 3);
        wait_n(8300);
        pulses(1, 3);
        chk("R6 expired window restarts", reg_rdata[7], 0);
        pulses(3, 3);
        chk("R6 new window reaches count", reg_rdata[7], 1);
        fast_fresh(2'b01);
        pulses(1, 3);
        wait_n(7900);
        pulses(3, 3);
        chk("R6 edges inside window", reg_rdata[7], 1);
        // R6 no tick, no ageing
        fast_fresh(2'b01);
        tick = 1'b0;
        pulses(2, 3);
        wait_n(9000);
        pulses(2, 3);
        chk("R6 window frozen without tick", reg_rdata[7], 1);
        tick = 1'b1;

        // R11 hardware set meets a write with flag bit 0
        fast_fresh(2'b00);
        @(negedge clk); fast_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_we = 1'b1; reg_wdata = ctl(2'b10, 1'b0, 1'b0, 2'b00);
        @(negedge clk); reg_we = 1'b0;
        wait_n(2);
        chk("R11 set wins over same-cycle write", reg_rdata[7], 1);
        @(negedge clk); fast_pin = 1'b0; wait_n(4);

        // R8 override gives pulses, no counting
        fast_fresh(2'b00);
        wr(ctl(2'b10, 1'b1, 1'b0, 2'b00));
        wdt_seen = 0;
        pulses(3, 4);
        chk("R8 one pulse per edge", wdt_seen, 6);
        chk("R8 no fast flag under override", reg_rdata[7], 0);
        wr(ctl(2'b10, 1'b0, 1'b0, 2'b00));
        wdt_seen = 0;
        pulses(1, 4);
        chk("R8 no pulse without override", wdt_seen, 0);

        // R4 disabled paths never flag
        wr(ctl(2'b01, 1'b0, 1'b0, 2'b00));
        pulses(2, 3);
        chk("R4 fast path off", reg_rdata[7], 0);
        wr(ctl(2'b10, 1'b0, 1'b0, 2'b00));
        wr(ctl(2'b10, 1'b0, 1'b0, 2'b00) & 8'h3F);
        wr(8'h00 | ctl(2'b10, 1'b0, 1'b0, 2'b00));
        wr(ctl(2'b00, 1'b0, 1'b0, 2'b00));
        @(negedge clk); slow_pin = 1'b1; wait_n(1200);
        chk("R4 slow path off", reg_rdata[6], 0);
        @(negedge clk); slow_pin = 1'b0; wait_n(4);

        // R7 short debounce
        wr(ctl(2'b01, 1'b0, 1'b0, 2'b00));
        @(negedge clk); slow_pin = 1'b1; wait_n(500);
        slow_pin = 1'b0; wait_n(1200);
        chk("R7 short excursion ignored", reg_rdata[6], 0);
        @(negedge clk); slow_pin = 1'b1; wait_n(1100);
        chk("R7 short debounce reached", reg_rdata[6], 1);
        chk("R3 irq with slow flag", irq, 1);
        wr(ctl(2'b01, 1'b0, 1'b1, 2'b00));
        chk("R2 clear slow flag", reg_rdata[6], 0);
        // R7 long debounce
        @(negedge clk); slow_pin = 1'b0; wait_n(2000);
        chk("R7 long debounce not yet", reg_rdata[6], 0);
        wait_n(14600);
        chk("R7 long debounce reached", reg_rdata[6], 1);
        wr(ctl(2'b00, 1'b0, 1'b0, 2'b00));

        // R5 random pulse trains against computed thresholds
        for (int it = 0; it < 10; it++) begin
            logic [1:0] cs = 2'($urandom);
            int n = int'($urandom_range(0, 40));
            int gap = int'($urandom_range(2, 50));
            fast_fresh(cs);
            pulses(n, gap);
            chk("R5 random train", reg_rdata[7], (n >= thr(cs)) ? 1 : 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule